// File: doc/BRIEF.md
# Receive Run-Length Expander

This block sits between a receive FIFO and a host-facing byte stream. Each FIFO entry is one byte plus a tag bit. A tagged entry is a run-length code, and its byte is a repeat count. The block moves entries through two holding stages. The second stage drives the output stream. When expansion is on, a tagged entry never reaches the stages: its byte is loaded into a down counter. The entry that follows it sits in the first stage and is copied into the second stage once per count. When the counter runs out, normal flow resumes.

When expansion is off, a tagged entry moves through both stages as data. Once it sits in the second stage, the byte stream stops and an interrupt is raised. The host reads that stage through a dedicated read strobe, which removes the entry and lets the stream continue. A FIFO reset or a device reset clears the counter and both stages.

Top module: `rlx_expander`

## Requirements
- R1: After reset, `out_valid` and `irq` are low, and no FIFO entry is popped while `fifo_empty` is high.
- R2: Untagged entries (bit 8 of `fifo_rd_data` equal to 0) appear on `out_data` once each, in FIFO order.
- R3: With `expand_en` high, a tagged entry (bit 8 equal to 1) met while no run is pending is consumed without appearing on the output. Its low byte becomes the repeat count.
- R4: The entry that follows a code is output exactly count times, for any count from 1 to 255. The counter drops by one for each copy.
- R5: After the last copy, the entries that follow pass through normally.
- R6: A count of zero produces no output and discards the entry that follows the code.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R8: With `expand_en` low, a tagged entry reaches the second stage and raises `irq`. Its byte appears on `host_tag_data`, never on `out_data`.
- R9: While `irq` is high, `out_valid` is low, and no later entry is output.
- R10: A `host_tag_rd` pulse while `irq` is high removes the tagged entry. `irq` falls and the stream resumes.
- R11: A `fifo_flush` pulse clears the counter and both stages. The next cycle shows `out_valid` and `irq` low, and any pending run is abandoned.
- R12: The entry right after a code is taken as the character to repeat even if it is itself tagged.
- R13: `fifo_rd_en` is only high when `fifo_empty` is low and `fifo_flush` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Device reset, active low, asynchronous |
| fifo_flush | input | 1 | FIFO reset pulse; clears counter and stages |
| expand_en | input | 1 | 1: expand run-length codes; 0: pass them to the host as tagged data |
| fifo_empty | input | 1 | FIFO has no entry |
| fifo_rd_data | input | DATA_W+1 | FIFO head entry; bit DATA_W is the tag, low bits the byte (show-ahead) |
| fifo_rd_en | output | 1 | Pops the FIFO head at the clock edge |
| out_valid | output | 1 | Output byte available |
| out_data | output | DATA_W | Output byte |
| out_ready | input | 1 | Consumer takes the byte when high with `out_valid` |
| host_tag_rd | input | 1 | Host read of the tagged holding stage |
| host_tag_data | output | DATA_W | Byte held in the second stage (tagged entry while `irq` is high) |
| irq | output | 1 | A tagged entry waits in the second stage |

## Verification
Plain bytes in sequence show that ordering and one-for-one transfer hold. Codes with counts 0, 1, 4 and 255 separate an off-by-one in the repeat counter from a dropped or leaked code byte. The same runs under a gapped `out_ready` show whether copies are lost or doubled when the consumer stalls. A tagged character after a code, a disabled-mode code that must stall the stream until the host read, and a flush in the middle of a long run each test a path where a stale state or counter would leave bytes stuck or repeated.

// File: rtl/rlx_pkg.sv
package rlx_pkg;

  // Run-length controller state
  typedef enum logic [1:0] {
    RL_IDLE  = 2'd0,  // no run pending
    RL_ARMED = 2'd1,  // count loaded, waiting for the character
    RL_RUN   = 2'd2   // first stage repeats its character
  } rl_state_e;

  // What happens to the FIFO head this cycle
  typedef enum logic [2:0] {
    ACT_NONE    = 3'd0,
    ACT_CODE    = 3'd1,  // tagged code goes into the counter
    ACT_DROP    = 3'd2,  // character after a zero count is discarded
    ACT_RUNCHAR = 3'd3,  // character to repeat enters stage one
    ACT_PLAIN   = 3'd4   // ordinary entry enters stage one
  } pop_act_e;

  function automatic logic act_fills_stage(input pop_act_e a);
    return (a == ACT_RUNCHAR) || (a == ACT_PLAIN);
  endfunction

endpackage

// File: rtl/rlx_pop_sel.sv
module rlx_pop_sel
  import rlx_pkg::*;
(
  input  logic      fifo_empty,
  input  logic      fifo_flush,
  input  logic      head_tag,
  input  logic      expand_en,
  input  logic      cnt_zero,
  input  logic      s1_room,
  input  rl_state_e state,
  output pop_act_e  act,
  output logic      pop
);

  always_comb begin
    act = ACT_NONE;
    if (!fifo_empty && !fifo_flush) begin
      case (state)
        RL_IDLE: begin
          if (expand_en && head_tag)
            act = ACT_CODE;
          else if (s1_room)
            act = ACT_PLAIN;
        end
        RL_ARMED: begin
          if (cnt_zero)
            act = ACT_DROP;
          else if (s1_room)
            act = ACT_RUNCHAR;
        end
        default: act = ACT_NONE;
      endcase
    end
    pop = (act != ACT_NONE);
  end

endmodule

// File: rtl/rlx_run_ctrl.sv
module rlx_run_ctrl
  import rlx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_flush,
  input  pop_act_e          act,
  input  logic [DATA_W-1:0] head_byte,
  input  logic              s1_move,
  output rl_state_e         state,
  output logic [DATA_W-1:0] cnt,
  output logic              cnt_zero,
  output logic              rep_last,
  output logic              run_active
);

  function automatic logic [DATA_W-1:0] step_down(input logic [DATA_W-1:0] c);
    return c - DATA_W'(1);
  endfunction

  assign cnt_zero   = (cnt == '0);
  assign run_active = (state == RL_RUN);
  assign rep_last   = run_active && (cnt == DATA_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RL_IDLE;
      cnt   <= '0;
    end else if (fifo_flush) begin
      state <= RL_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        RL_IDLE: begin
          if (act == ACT_CODE) begin
            cnt   <= head_byte;
            state <= RL_ARMED;
          end
        end
        RL_ARMED: begin
          if (act == ACT_DROP)
            state <= RL_IDLE;
          else if (act == ACT_RUNCHAR)
            state <= RL_RUN;
        end
        RL_RUN: begin
          if (s1_move) begin
            cnt <= step_down(cnt);
            if (rep_last) state <= RL_IDLE;
          end
        end
        default: state <= RL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rlx_hold_pipe.sv
module rlx_hold_pipe #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_flush,
  input  logic              load_en,
  input  logic              load_tag,
  input  logic              load_rep,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              rep_last,
  input  logic              out_ready,
  input  logic              host_tag_rd,
  output logic              s1_room,
  output logic              s1_move,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              irq,
  output logic [DATA_W-1:0] host_tag_data
);

  // stage one
  logic              s1_valid, s1_tag, s1_rep;
  logic [DATA_W-1:0] s1_byte;
  // stage two
  logic              s2_valid, s2_tag;
  logic [DATA_W-1:0] s2_byte;

  logic s2_stream_take, s2_host_take, s2_free, s1_leave;

  assign out_valid      = s2_valid && !s2_tag;
  assign out_data       = s2_byte;
  assign irq            = s2_valid && s2_tag;
  assign host_tag_data  = s2_byte;

  assign s2_stream_take = out_valid && out_ready;
  assign s2_host_take   = irq && host_tag_rd;
  assign s2_free        = !s2_valid || s2_stream_take || s2_host_take;

  assign s1_move  = s1_valid && s2_free;
  assign s1_leave = s1_move && (!s1_rep || rep_last);
  assign s1_room  = !s1_valid || s1_leave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_tag   <= 1'b0;
      s1_rep   <= 1'b0;
      s1_byte  <= '0;
    end else if (fifo_flush) begin
      s1_valid <= 1'b0;
      s1_tag   <= 1'b0;
      s1_rep   <= 1'b0;
    end else if (load_en) begin
      s1_valid <= 1'b1;
      s1_tag   <= load_tag;
      s1_rep   <= load_rep;
      s1_byte  <= load_byte;
    end else if (s1_leave) begin
      s1_valid <= 1'b0;
      s1_rep   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_tag   <= 1'b0;
      s2_byte  <= '0;
    end else if (fifo_flush) begin
      s2_valid <= 1'b0;
      s2_tag   <= 1'b0;
    end else if (s1_move) begin
      s2_valid <= 1'b1;
      s2_tag   <= s1_tag;
      s2_byte  <= s1_byte;
    end else if (s2_stream_take || s2_host_take) begin
      s2_valid <= 1'b0;
      s2_tag   <= 1'b0;
    end
  end

endmodule

// File: rtl/rlx_expander.sv
module rlx_expander
  import rlx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_flush,
  input  logic              expand_en,
  input  logic              fifo_empty,
  input  logic [DATA_W:0]   fifo_rd_data,
  output logic              fifo_rd_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  input  logic              host_tag_rd,
  output logic [DATA_W-1:0] host_tag_data,
  output logic              irq
);

  localparam int unsigned TAG_BIT = DATA_W;

  logic              head_tag;
  logic [DATA_W-1:0] head_byte;
  pop_act_e          w_act;
  rl_state_e         w_state;
  logic [DATA_W-1:0] w_cnt;
  logic              w_cnt_zero, w_rep_last, w_run_active;
  logic              w_s1_room, w_s1_move;
  logic              w_load_en, w_load_tag, w_load_rep;

  assign head_tag   = fifo_rd_data[TAG_BIT];
  assign head_byte  = fifo_rd_data[DATA_W-1:0];
  assign w_load_en  = act_fills_stage(w_act);
  assign w_load_rep = (w_act == ACT_RUNCHAR);
  assign w_load_tag = (w_act == ACT_PLAIN) && head_tag;

  rlx_pop_sel u_pop_sel (
    .fifo_empty (fifo_empty),
    .fifo_flush (fifo_flush),
    .head_tag   (head_tag),
    .expand_en  (expand_en),
    .cnt_zero   (w_cnt_zero),
    .s1_room    (w_s1_room),
    .state      (w_state),
    .act        (w_act),
    .pop        (fifo_rd_en)
  );

  rlx_run_ctrl #(.DATA_W(DATA_W)) u_run_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_flush (fifo_flush),
    .act        (w_act),
    .head_byte  (head_byte),
    .s1_move    (w_s1_move),
    .state      (w_state),
    .cnt        (w_cnt),
    .cnt_zero   (w_cnt_zero),
    .rep_last   (w_rep_last),
    .run_active (w_run_active)
  );

  rlx_hold_pipe #(.DATA_W(DATA_W)) u_hold_pipe (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_flush    (fifo_flush),
    .load_en       (w_load_en),
    .load_tag      (w_load_tag),
    .load_rep      (w_load_rep),
    .load_byte     (head_byte),
    .rep_last      (w_rep_last),
    .out_ready     (out_ready),
    .host_tag_rd   (host_tag_rd),
    .s1_room       (w_s1_room),
    .s1_move       (w_s1_move),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .irq           (irq),
    .host_tag_data (host_tag_data)
  );

endmodule

// File: rtl/rlx_expander_chk.sv
module rlx_expander_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_flush,
  input logic              fifo_empty,
  input logic              fifo_rd_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              irq,
  input logic              host_tag_rd,
  input logic              s1_move,
  input logic              run_active,
  input logic [DATA_W-1:0] cnt
);

  p_pop_when_avail_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |-> (!fifo_empty && !fifo_flush));

  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !fifo_flush) |=> (out_valid && $stable(out_data)));

  p_irq_blocks_stream_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !out_valid);

  p_host_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && host_tag_rd && !s1_move && !fifo_flush) |=> !irq);

  p_count_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && s1_move && !fifo_flush) |=> (cnt == DATA_W'($past(cnt) - DATA_W'(1))));

  p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> (cnt == '0 && !out_valid && !irq));

endmodule

bind rlx_expander rlx_expander_chk #(.DATA_W(DATA_W)) u_rlx_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_flush  (fifo_flush),
  .fifo_empty  (fifo_empty),
  .fifo_rd_en  (fifo_rd_en),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .irq         (irq),
  .host_tag_rd (host_tag_rd),
  .s1_move     (w_s1_move),
  .run_active  (w_run_active),
  .cnt         (w_cnt)
);

// File: tb/rlx_expander_tb_top.sv
`timescale 1ns/1ps
module rlx_expander_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_flush = 1'b0;
  logic       expand_en = 1'b1;
  logic       fifo_empty;
  logic [8:0] fifo_rd_data;
  logic       fifo_rd_en;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;
  logic       host_tag_rd = 1'b0;
  logic [7:0] host_tag_data;
  logic       irq;

  always #4 clk = ~clk;

  rlx_expander #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_flush(fifo_flush), .expand_en(expand_en),
    .fifo_empty(fifo_empty), .fifo_rd_data(fifo_rd_data), .fifo_rd_en(fifo_rd_en),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .host_tag_rd(host_tag_rd), .host_tag_data(host_tag_data), .irq(irq)
  );

  // FIFO model, show-ahead
  logic [8:0] fifo_mem [256];
  logic [7:0] wr_ptr = 8'd0;
  logic [7:0] rd_ptr = 8'd0;
  assign fifo_empty   = (rd_ptr == wr_ptr);
  assign fifo_rd_data = fifo_mem[rd_ptr];
  always @(posedge clk) begin
    if (fifo_flush) rd_ptr <= wr_ptr;
    else if (fifo_rd_en) rd_ptr <= rd_ptr + 8'd1;
  end

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  int ready_mode = 0;  // 0 always, 1 gapped, 2 held low
  logic [7:0] recv [$];
  logic [7:0] expq [$];

  // consumer: decides out_ready after the negedge drive, records handshakes
  always @(negedge clk) begin
    #1;
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = ((cyc % 3) != 1);
      default: out_ready = 1'b0;
    endcase
    if (rst_n && out_valid && out_ready) recv.push_back(out_data);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_errors++;
      $display("FAIL R1 watchdog expired: actual %0d cycles expected < 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic tag, input logic [7:0] b);
    fifo_mem[wr_ptr] = {tag, b};
    wr_ptr = wr_ptr + 8'd1;
  endtask

  task automatic drain();
    int idle = 0;
    for (int i = 0; i < 2000 && idle < 4; i++) begin
      @(negedge clk);
      #2;
      if (fifo_empty && !out_valid && !irq) idle++;
      else idle = 0;
    end
  endtask

  task automatic compare(input string req);
    check(recv.size() == expq.size(), {req, " length"}, recv.size(), expq.size());
    for (int i = 0; i < expq.size() && i < recv.size(); i++)
      check(recv[i] == expq[i], req, int'(recv[i]), int'(expq[i]));
    recv.delete();
    expq.delete();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    check(!irq, "R1 irq after reset", int'(irq), 0);
    check(!fifo_rd_en, "R1 no pop when empty", int'(fifo_rd_en), 0);
  endtask

  task automatic t_plain();
    ready_mode = 0;
    for (int i = 0; i < 6; i++) begin
      push(1'b0, 8'(8'h30 + i));
      expq.push_back(8'(8'h30 + i));
    end
    drain();
    compare("R2 plain order");
  endtask

  task automatic t_run();
    ready_mode = 0;
    push(1'b1, 8'd4); push(1'b0, 8'h41); push(1'b0, 8'h42);
    repeat (4) expq.push_back(8'h41);
    expq.push_back(8'h42);
    drain();
    compare("R3 R4 R5 run of four");
  endtask

  task automatic t_short_counts();
    ready_mode = 0;
    push(1'b1, 8'd0); push(1'b0, 8'h58);
    push(1'b1, 8'd1); push(1'b0, 8'h5A);
    push(1'b0, 8'h59);
    expq.push_back(8'h5A); expq.push_back(8'h59);
    drain();
    compare("R6 zero and one counts");
  endtask

  task automatic t_backpressure();
    ready_mode = 1;
    push(1'b0, 8'h10); push(1'b0, 8'h11);
    push(1'b1, 8'd3); push(1'b0, 8'h22); push(1'b0, 8'h33);
    expq.push_back(8'h10); expq.push_back(8'h11);
    repeat (3) expq.push_back(8'h22);
    expq.push_back(8'h33);
    drain();
    compare("R7 gapped ready");
    ready_mode = 0;
  endtask

  task automatic t_max_count();
    ready_mode = 0;
    push(1'b1, 8'd255); push(1'b0, 8'h77); push(1'b0, 8'h78);
    repeat (255) expq.push_back(8'h77);
    expq.push_back(8'h78);
    drain();
    compare("R4 count 255");
  endtask

  task automatic t_armed_tagged();
    ready_mode = 0;
    push(1'b1, 8'd2); push(1'b1, 8'h41); push(1'b0, 8'h43);
    expq.push_back(8'h41); expq.push_back(8'h41); expq.push_back(8'h43);
    drain();
    compare("R12 tagged character after code");
  endtask

  task automatic t_disabled();
    int waited = 0;
    ready_mode = 0;
    expand_en = 1'b0;
    push(1'b0, 8'h01); push(1'b1, 8'h05); push(1'b0, 8'h02);
    while (!irq && waited < 50) begin
      @(negedge clk); #2;
      waited++;
    end
    check(irq, "R8 irq raised", int'(irq), 1);
    check(host_tag_data == 8'h05, "R8 tagged byte", int'(host_tag_data), 5);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #2;
      check(!out_valid && irq, "R9 stream stalled", int'(out_valid), 0);
    end
    check(recv.size() == 1, "R9 only first byte out", recv.size(), 1);
    @(negedge clk);
    host_tag_rd = 1'b1;
    @(negedge clk);
    host_tag_rd = 1'b0;
    #2;
    check(!irq, "R10 irq cleared by host read", int'(irq), 0);
    expq.push_back(8'h01); expq.push_back(8'h02);
    drain();
    compare("R10 stream resumes");
    expand_en = 1'b1;
  endtask

  task automatic t_flush();
    ready_mode = 0;
    push(1'b1, 8'd200); push(1'b0, 8'h46);
    repeat (10) @(negedge clk);
    ready_mode = 2;
    fifo_flush = 1'b1;
    @(negedge clk);
    fifo_flush = 1'b0;
    #2;
    check(!out_valid, "R11 out_valid after flush", int'(out_valid), 0);
    check(!irq, "R11 irq after flush", int'(irq), 0);
    recv.delete();
    ready_mode = 0;
    push(1'b0, 8'h51);
    expq.push_back(8'h51);
    drain();
    compare("R11 run abandoned");
  endtask

  initial begin
    t_reset();
    t_plain();
    t_run();
    t_short_counts();
    t_backpressure();
    t_max_count();
    t_armed_tagged();
    t_disabled();
    t_flush();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule